// File: doc/BRIEF.md
# Byte-Loaded Compare Timer with Deferred Reload

The block is a free-running up counter paired with a compare value that an 8-bit register port loads one byte at a time. Writes to the lower byte only fill a staging byte. A write to the upper byte joins it with the staged byte and commits the whole value in one clock, so the compare value never holds a half-updated mix. A deferral enable chooses what happens to a commit made while the timer runs. With deferral off, the live compare value changes at once. With deferral on, the value waits in a pending register and moves into the live register on the next match.

On every match the block raises a one-clock interrupt pulse and restarts the count from zero. A controller state machine has three states. TS_STOP holds the count at zero. TS_RUN counts. TS_HIT is the single clock after a match, in which the interrupt is high and the count is zero. Its transitions are: *start* (TS_STOP to TS_RUN when run goes high), *match* (TS_RUN to TS_HIT), *continue* (TS_HIT to TS_RUN), *rematch* (TS_HIT to TS_HIT when the compare value is zero), and *halt* (any state to TS_STOP when run goes low).

Top module: `dct_timer`

## Requirements
- R1: After reset the count is 0, the interrupt is low, the staging byte is 0x00, and both the pending and live compare values are 0xFFFF. A read of either byte returns 0xFF.
- R2: A write at address 0 (low byte) only loads the staging byte. The compare value read back does not change.
- R3: A write at address 1 (high byte) commits {written byte, staging byte} as a 16-bit value in that clock.
- R4: In TS_STOP a commit loads both the pending and live compare values, whatever the deferral setting.
- R5: In TS_RUN and TS_HIT the count rises by one per clock and wraps from 0xFFFF to 0. When run is low the count is 0 one clock later and stays 0.
- R6: When the running count equals the live compare value, the next clock shows the interrupt high for exactly one clock with the count at 0. With compare value C, pulses therefore come every C+1 clocks.
- R7: With deferral on (dbuf_en_i=1) and the timer running, a commit changes only the pending value. The next match still uses the old live value.
- R8: With deferral on, a match copies the pending value into the live register, and later matches use it.
- R9: With deferral on, reads return the pending value. With deferral off, reads return the live value.
- R10: With deferral off and the timer running, a commit updates the live value at once. If the new value is below the count, the next match only comes after the count wraps.
- R11: If a commit and a match fall in the same clock with deferral on, the live register takes the old pending value and the pending register takes the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = count, 0 = stop and clear |
| dbuf_en_i | input | 1 | 1 = defer running commits until a match |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Byte select: 0 low, 1 high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected byte |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | One-clock match interrupt pulse |

## Verification
On every cycle the assertions check four things. A low-byte write leaves the pending value alone. A stopped or non-deferred commit leaves the live and pending values equal. A deferred running commit without a match keeps the live value. A deferred match loads the previous pending value. They also check that the count steps by one or sits at zero, and that each interrupt follows a match with the count cleared. Only the bench scenarios can show the whole-period effects. These are the old live value still governing the first period after a deferred commit, the near-full wrap after a non-deferred commit below the count, and the period that follows a commit landing in the same clock as a match.

// File: rtl/dct_pkg.sv
package dct_pkg;

    // Controller states of the compare timer
    typedef enum logic [1:0] {
        TS_STOP = 2'd0,
        TS_RUN  = 2'd1,
        TS_HIT  = 2'd2
    } tmr_state_t;

    localparam int unsigned DCT_CW = 16;
    localparam int unsigned DCT_BW = 8;

endpackage

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int unsigned CW = DCT_CW,
    parameter int unsigned BW = DCT_BW,
    localparam int unsigned NB = CW / BW,
    localparam int unsigned AW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    input  logic          stopped,
    input  logic          dbuf_en,
    input  logic          hit,
    output logic [CW-1:0] active,
    output logic [CW-1:0] shadow
);

    localparam logic [AW-1:0] TOP_IDX = AW'(NB - 1);

    logic [CW-1:0] commit_val;
    logic          commit;

    assign commit = wr_en && (addr == TOP_IDX);

    // Staging bytes for every byte below the top one
    genvar gi;
    generate
        for (gi = 0; gi < NB - 1; gi++) begin : g_stage
            logic [BW-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else if (wr_en && (addr == AW'(gi))) begin
                    stage_q <= wdata;
                end
            end
            assign commit_val[gi*BW +: BW] = stage_q;
        end
    endgenerate
    assign commit_val[(NB-1)*BW +: BW] = wdata;

    // Pending (shadow) compare value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '1;
        end else if (commit) begin
            shadow <= commit_val;
        end
    end

    // Live compare value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= '1;
        end else if (commit && (stopped || !dbuf_en)) begin
            active <= commit_val;
        end else if (hit && dbuf_en) begin
            active <= shadow;
        end
    end

    assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr != TOP_IDX)) |=> $stable(shadow));

    assert_stopped_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && stopped) |=> (active == shadow));

    assert_dbuf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !stopped && dbuf_en && !hit) |=> $stable(active));

    assert_match_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && dbuf_en && !(commit && stopped)) |=> (active == $past(shadow)));

    assert_direct_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !dbuf_en) |=> (active == shadow));

endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
    import dct_pkg::*;
#(
    parameter int unsigned CW = DCT_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] active,
    output logic [CW-1:0] count_o,
    output logic          hit_o,
    output logic          stopped_o,
    output logic          irq_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    tmr_state_t state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic          running;

    assign running = (state_q != TS_STOP);
    assign hit_o   = running && (count_q == active);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_STOP: state_d = run_i ? TS_RUN : TS_STOP;           // start
            TS_RUN:  state_d = !run_i ? TS_STOP :
                               (hit_o ? TS_HIT : TS_RUN);          // halt / match
            TS_HIT:  state_d = !run_i ? TS_STOP :
                               (hit_o ? TS_HIT : TS_RUN);          // halt / rematch / continue
            default: state_d = TS_STOP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter
    always_comb begin
        if (!running || !run_i || hit_o) begin
            count_d = '0;
        end else begin
            count_d = count_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // Outputs
    always_comb begin
        irq_o     = (state_q == TS_HIT);
        stopped_o = (state_q == TS_STOP);
        count_o   = count_q;
    end

    assert_stop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |-> (count_o == '0));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped_o && run_i && !hit_o) |=> (count_o == $past(count_o) + ONE));

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(hit_o) && (count_o == '0)));

endmodule

// File: rtl/dct_rdmux.sv
module dct_rdmux
    import dct_pkg::*;
#(
    parameter int unsigned CW = DCT_CW,
    parameter int unsigned BW = DCT_BW,
    localparam int unsigned NB = CW / BW,
    localparam int unsigned AW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [CW-1:0] active,
    input  logic [CW-1:0] shadow,
    input  logic          dbuf_en,
    input  logic [AW-1:0] addr,
    output logic [BW-1:0] rdata
);

    logic [CW-1:0] view;
    logic [BW-1:0] bytes [NB];

    assign view = dbuf_en ? shadow : active;

    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_byte
            assign bytes[gi] = view[gi*BW +: BW];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr == AW'(i)) begin
                rdata = bytes[i];
            end
        end
    end

endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int unsigned CW = DCT_CW,
    parameter int unsigned BW = DCT_BW,
    localparam int unsigned NB = CW / BW,
    localparam int unsigned AW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          dbuf_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] rdata_o,
    output logic [CW-1:0] count_o,
    output logic          irq_o
);

    logic [CW-1:0] active;
    logic [CW-1:0] shadow;
    logic          hit;
    logic          stopped;

    dct_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .active   (active),
        .count_o  (count_o),
        .hit_o    (hit),
        .stopped_o(stopped),
        .irq_o    (irq_o)
    );

    dct_regs #(.CW(CW), .BW(BW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .addr   (addr_i),
        .wdata  (wdata_i),
        .stopped(stopped),
        .dbuf_en(dbuf_en_i),
        .hit    (hit),
        .active (active),
        .shadow (shadow)
    );

    dct_rdmux #(.CW(CW), .BW(BW)) u_rdmux (
        .active (active),
        .shadow (shadow),
        .dbuf_en(dbuf_en_i),
        .addr   (addr_i),
        .rdata  (rdata_o)
    );

    assert_irq_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (count_o == '0));

endmodule

// File: tb/dct_timer_test.sv
module dct_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        dbuf_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [0:0]  addr_i = 1'b0;
    logic [7:0]  wdata_i = 8'h00;
    logic [7:0]  rdata_o;
    logic [15:0] count_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dct_timer uut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .dbuf_en_i(dbuf_en_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .count_o(count_o), .irq_o(irq_o)
    );

    // Behavioural reference model
    int m_state = 0;   // 0 stopped, 1 counting, 2 pulse clock
    int m_cnt = 0;
    int m_stage = 0;
    int m_pend = 'hFFFF;
    int m_live = 'hFFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_stage = 0; m_pend = 'hFFFF; m_live = 'hFFFF;
        end else begin
            automatic bit going = (m_state != 0);
            automatic bit match = going && (m_cnt == m_live);
            automatic int nv = (int'(wdata_i) << 8) | m_stage;
            automatic bit cm = wr_en_i && (addr_i == 1'b1);
            if (cm && (!going || !dbuf_en_i)) m_live = nv;
            else if (match && dbuf_en_i) m_live = m_pend;
            if (cm) m_pend = nv;
            if (wr_en_i && addr_i == 1'b0) m_stage = int'(wdata_i);
            if (!going || !run_i || match) m_cnt = 0;
            else m_cnt = (m_cnt + 1) % 65536;
            if (!run_i) m_state = 0;
            else if (going && match) m_state = 2;
            else m_state = 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int model_read();
        int v = dbuf_en_i ? m_pend : m_live;
        return addr_i ? (v >> 8) & 255 : v & 255;
    endfunction

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R5 count", int'(count_o), m_cnt);
            chk("R6 irq", int'(irq_o), (m_state == 2) ? 1 : 0);
            chk("R9 read", int'(rdata_o), model_read());
        end
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        tick(1);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin tick(1); n++; end while (!irq_o && n < 70000);
    endtask

    task automatic rd(logic a, output int v);
        addr_i = a; #1; v = int'(rdata_o);
    endtask

    initial begin
        int n;
        int v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        rd(0, v); chk("R1 low byte", v, 'hFF);
        rd(1, v); chk("R1 high byte", v, 'hFF);

        // R2 staging only, R3/R4 commit while stopped
        wr(0, 8'h34);
        rd(0, v); chk("R2 low unchanged", v, 'hFF);
        wr(1, 8'h12);
        rd(0, v); chk("R3 low committed", v, 'h34);
        rd(1, v); chk("R3 high committed", v, 'h12);
        dbuf_en_i = 1'b1;
        rd(0, v); chk("R4 pending equals live", v, 'h34);
        dbuf_en_i = 1'b0;

        // R6 period with compare 5
        wr(0, 8'd5); wr(1, 8'h00);
        run_i = 1'b1;
        wait_irq(n);
        chk("R6 count zero at pulse", int'(count_o), 0);
        wait_irq(n);
        chk("R6 period", n, 6);
        tick(1);
        chk("R6 single clock", int'(irq_o), 0);

        // R7/R8 deferred reload
        dbuf_en_i = 1'b1;
        wr(0, 8'd8);
        wait_irq(n);
        wr(1, 8'h00);
        rd(0, v); chk("R9 pending readback", v, 8);
        wait_irq(n);
        chk("R7 old live value kept", n + 1, 6);
        wait_irq(n);
        chk("R8 new value used", n, 9);

        // R9 read source follows deferral setting
        wr(0, 8'd20); wr(1, 8'h00);
        dbuf_en_i = 1'b0;
        rd(0, v); chk("R9 live readback", v, 8);
        dbuf_en_i = 1'b1;
        rd(0, v); chk("R9 pending readback", v, 20);
        dbuf_en_i = 1'b0;

        // R10 immediate commit
        wr(0, 8'd3);
        wait_irq(n);
        wr(1, 8'h00);
        wait_irq(n);
        chk("R10 immediate period", n + 1, 4);
        wr(0, 8'd100);
        wait_irq(n);
        wr(1, 8'h00);
        wr(0, 8'd10);
        while (count_o != 16'd60) tick(1);
        wr(1, 8'h00);
        chk("R10 count after late commit", int'(count_o), 61);
        wait_irq(n);
        chk("R10 match after wrap", n, 65486);

        // R11 commit and match in the same clock
        run_i = 1'b0;
        tick(2);
        chk("R5 stopped count", int'(count_o), 0);
        wr(0, 8'd4); wr(1, 8'h00);
        dbuf_en_i = 1'b1;
        wr(0, 8'd6);
        run_i = 1'b1;
        tick(1);
        wr(1, 8'h00);
        wr(0, 8'd9);
        while (count_o != 16'd4) tick(1);
        wr(1, 8'h00);
        chk("R11 match pulse", int'(irq_o), 1);
        rd(0, v); chk("R11 pending holds new", v, 9);
        wait_irq(n);
        chk("R11 live took old pending", n, 7);
        wait_irq(n);
        chk("R11 new value later", n, 10);

        // R5 stop clears
        run_i = 1'b0;
        tick(1);
        chk("R5 cleared on stop", int'(count_o), 0);
        tick(3);
        chk("R5 held at zero", int'(count_o), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule